// File: doc/BRIEF.md
# Radix-4 SRT Digit Selector

This block picks the next digit of a radix-4 SRT divide or square-root recurrence. Each step it takes the top bits of the partial remainder, already in two's-complement (non-redundant) form, and a short index made of the leading fraction bits of the divisor or root estimate. The index selects a set of four selection thresholds. The remainder is tested against each threshold by taking the sign of the difference. The four test results form a thermometer code, which the block turns into a digit in the set {-2, -1, 0, 1, 2}.

The digit leaves the block in two forms. The first is a one-hot 5-bit vector that can drive the select lines of the 5:1 remainder multiplexers directly. The second is a signed 3-bit value for the converter that builds the root estimate. The block does not add up the remainder and does not keep the root estimate. By default the outputs are registered and appear one cycle after the inputs. A parameter can make the path purely combinational instead.

The remainder input is 8 bits. Its value is the input read as a signed integer divided by 16. The index is 3 bits. Threshold set i is built from the divisor midpoint d = 17 + 2*i, counted in the same 1/16 units. The thresholds are:
- T2 = floor(3*d/2)
- T1 = floor(d/2)
- T0 = -T1
- Tm = -T2

Top module: `srt_digit_select`

## Requirements
- R1: When the signed remainder r is at or above T2 for the index in use, the digit is +2. The largest positive input 8'h7F always gives +2.
- R2: When T1 <= r < T2, the digit is +1.
- R3: When T0 <= r < T1, the digit is 0.
- R4: When Tm <= r < T0, the digit is -1.
- R5: When r < Tm, the digit is -2. The most negative input 8'h80 always gives -2.
- R6: The one-hot output always has exactly one bit set. Bit 4 means +2, bit 3 means +1, bit 2 means 0, bit 1 means -1 and bit 0 means -2.
- R7: The signed digit output is the two's-complement 3-bit form of the digit marked in the one-hot output (2 = 3'b010, -2 = 3'b110).
- R8: With the default registered variant, a digit accepted while valid_in is high appears one clock later, with valid_out high. valid_out is low one clock after valid_in is low.
- R9: While valid_in is low, the digit outputs keep their last value, whatever the remainder and index inputs do.
- R10: During reset (rst_n low, asynchronous), valid_out is 0, the one-hot output is 5'b00100 and the signed digit is 0.
- R11: The four threshold tests always form a thermometer code. So for a fixed index, the digit never decreases as the remainder increases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| valid_in | input | 1 | Remainder and index are valid this cycle |
| rem_msbs | input | 8 | Top remainder bits, two's complement, 4 fraction bits |
| div_idx | input | 3 | Leading fraction bits of divisor or root estimate |
| valid_out | output | 1 | Digit outputs carry a new digit |
| digit_onehot | output | 5 | One-hot digit, bit 4 = +2 down to bit 0 = -2 |
| digit_val | output | 3 | Signed digit, two's complement |

## Verification
Some properties are checked on every cycle. These are:
- the thermometer shape of the four threshold tests;
- the single set bit of the one-hot output;
- the agreement between the one-hot and signed forms;
- the one-cycle validity timing;
- the hold while valid_in is low;
- the digits forced by the two extreme remainder values.

Whether each digit lands in the correct region for every index needs the bench's reference model. The bench sweeps every remainder for every index, hits each threshold and its neighbour below, and runs random traffic with gaps. The same sweep also shows that the digit never decreases as the remainder rises.

// File: rtl/srt_sel_pkg.sv
package srt_sel_pkg;

   localparam int NUM_CMP = 4;   // thresholds: 0=T2, 1=T1, 2=T0, 3=Tm
   localparam int NUM_DIG = 5;   // digits -2..+2

   typedef logic [NUM_DIG-1:0] digit_oh_t;
   typedef logic signed [2:0]  digit_sv_t;

   localparam digit_oh_t OH_ZERO = 5'b00100;

   // divisor midpoint in remainder LSB units
   function automatic int mid_units(input int idx, input int idx_w, input int rem_frac);
      int base;
      base = ((1 << idx_w) + idx) * 2 + 1;
      return base << (rem_frac - idx_w - 1);
   endfunction

   // threshold k for table entry idx
   function automatic int sel_const(input int idx, input int k, input int idx_w, input int rem_frac);
      int d;
      d = mid_units(idx, idx_w, rem_frac);
      case (k)
         0:       return (3 * d) >>> 1;
         1:       return d >>> 1;
         2:       return -(d >>> 1);
         default: return -((3 * d) >>> 1);
      endcase
   endfunction

endpackage

// File: rtl/srt_sel_const_rom.sv
module srt_sel_const_rom #(
   parameter int REM_W    = 8,
   parameter int IDX_W    = 3,
   parameter int REM_FRAC = 4
) (
   input  logic [IDX_W-1:0]                         idx,
   output logic [srt_sel_pkg::NUM_CMP*REM_W-1:0]    thr_flat
);
   import srt_sel_pkg::*;

   localparam int NENT = 1 << IDX_W;

   logic [REM_W-1:0] tbl [NENT][NUM_CMP];

   for (genvar e = 0; e < NENT; e++) begin : g_ent
      for (genvar k = 0; k < NUM_CMP; k++) begin : g_thr
         localparam int V = sel_const(e, k, IDX_W, REM_FRAC);
         assign tbl[e][k] = V[REM_W-1:0];
      end
   end

   for (genvar k = 0; k < NUM_CMP; k++) begin : g_out
      assign thr_flat[k*REM_W +: REM_W] = tbl[idx][k];
   end

endmodule

// File: rtl/srt_sel_cmp_bank.sv
module srt_sel_cmp_bank #(
   parameter int REM_W = 8
) (
   input  logic [REM_W-1:0]                       rem,
   input  logic [srt_sel_pkg::NUM_CMP*REM_W-1:0]  thr_flat,
   output logic [srt_sel_pkg::NUM_CMP-1:0]        below
);
   import srt_sel_pkg::*;

   // each bit is the sign of (rem - threshold), done as a signed compare
   for (genvar k = 0; k < NUM_CMP; k++) begin : g_cmp
      logic signed [REM_W-1:0] thr_k;
      assign thr_k    = thr_flat[k*REM_W +: REM_W];
      assign below[k] = $signed(rem) < thr_k;
   end

endmodule

// File: rtl/srt_sel_decode.sv
module srt_sel_decode (
   input  logic [srt_sel_pkg::NUM_CMP-1:0] below,
   output srt_sel_pkg::digit_oh_t          oh,
   output srt_sel_pkg::digit_sv_t          dig
);
   import srt_sel_pkg::*;

   // edges of the thermometer give the one-hot select
   assign oh[NUM_DIG-1] = ~below[0];
   assign oh[0]         = below[NUM_CMP-1];
   for (genvar k = 1; k < NUM_CMP; k++) begin : g_mid
      assign oh[NUM_DIG-1-k] = below[k-1] & ~below[k];
   end

   // signed digit from population count, independent of the one-hot path
   logic [2:0] ones;
   always_comb begin
      ones = '0;
      for (int k = 0; k < NUM_CMP; k++) ones = ones + {2'b00, below[k]};
   end
   assign dig = 3'd2 - ones;

endmodule

// File: rtl/srt_digit_select.sv
module srt_digit_select #(
   parameter int REM_W    = 8,
   parameter int IDX_W    = 3,
   parameter int REM_FRAC = 4,
   parameter bit REG_OUT  = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             valid_in,
   input  logic [REM_W-1:0] rem_msbs,
   input  logic [IDX_W-1:0] div_idx,
   output logic             valid_out,
   output logic [4:0]       digit_onehot,
   output logic [2:0]       digit_val
);
   import srt_sel_pkg::*;

   localparam int NENT    = 1 << IDX_W;
   localparam int THR_MAX = sel_const(NENT - 1, 0, IDX_W, REM_FRAC);
   localparam int POS_MAX = (1 << (REM_W - 1)) - 1;

   if (REM_W < 4) begin : g_bad_w
      $error("REM_W must be at least 4");
   end
   if (IDX_W < 1 || IDX_W > 6) begin : g_bad_i
      $error("IDX_W must lie in 1..6");
   end
   if (REM_FRAC < IDX_W + 1) begin : g_bad_f
      $error("REM_FRAC must exceed IDX_W");
   end
   if (THR_MAX >= POS_MAX) begin : g_bad_t
      $error("largest threshold does not fit the remainder width");
   end

   logic [NUM_CMP*REM_W-1:0] thr_flat;
   logic [NUM_CMP-1:0]       cmp_lt;
   digit_oh_t                oh_c;
   digit_sv_t                dig_c;

   srt_sel_const_rom #(.REM_W(REM_W), .IDX_W(IDX_W), .REM_FRAC(REM_FRAC)) u_rom (
      .idx      (div_idx),
      .thr_flat (thr_flat)
   );

   srt_sel_cmp_bank #(.REM_W(REM_W)) u_cmp (
      .rem      (rem_msbs),
      .thr_flat (thr_flat),
      .below    (cmp_lt)
   );

   srt_sel_decode u_dec (
      .below (cmp_lt),
      .oh    (oh_c),
      .dig   (dig_c)
   );

   if (REG_OUT) begin : g_reg
      logic      valid_q;
      digit_oh_t oh_q;
      digit_sv_t dig_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            valid_q <= 1'b0;
            oh_q    <= OH_ZERO;
            dig_q   <= '0;
         end else begin
            valid_q <= valid_in;
            if (valid_in) begin
               oh_q  <= oh_c;
               dig_q <= dig_c;
            end
         end
      end
      assign valid_out    = valid_q;
      assign digit_onehot = oh_q;
      assign digit_val    = dig_q;
   end else begin : g_comb
      assign valid_out    = valid_in;
      assign digit_onehot = oh_c;
      assign digit_val    = dig_c;
   end

endmodule

// File: rtl/srt_digit_select_chk.sv
module srt_digit_select_chk #(
   parameter int REM_W   = 8,
   parameter bit REG_OUT = 1'b1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             valid_in,
   input logic [REM_W-1:0] rem_msbs,
   input logic             valid_out,
   input logic [4:0]       digit_onehot,
   input logic [2:0]       digit_val,
   input logic [3:0]       cmp_lt
);
   logic [2:0] oh_as_val;
   always_comb begin
      case (digit_onehot)
         5'b10000: oh_as_val = 3'b010;
         5'b01000: oh_as_val = 3'b001;
         5'b00100: oh_as_val = 3'b000;
         5'b00010: oh_as_val = 3'b111;
         default:  oh_as_val = 3'b110;
      endcase
   end

   a_r11_thermometer: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_lt & (cmp_lt + 4'd1)) == 4'd0);

   a_r6_single_hot: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(digit_onehot) == 1);

   a_r7_forms_agree: assert property (@(posedge clk) disable iff (!rst_n)
      digit_val == oh_as_val);

   if (REG_OUT) begin : g_seq
      a_r8_valid_high: assert property (@(posedge clk) disable iff (!rst_n)
         valid_in |=> valid_out);
      a_r8_valid_low: assert property (@(posedge clk) disable iff (!rst_n)
         !valid_in |=> !valid_out);
      a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
         !valid_in |=> ($stable(digit_onehot) && $stable(digit_val)));
      a_r1_top_value: assert property (@(posedge clk) disable iff (!rst_n)
         (valid_in && rem_msbs == {1'b0, {(REM_W-1){1'b1}}}) |=> digit_onehot == 5'b10000);
      a_r5_bottom_value: assert property (@(posedge clk) disable iff (!rst_n)
         (valid_in && rem_msbs == {1'b1, {(REM_W-1){1'b0}}}) |=> digit_onehot == 5'b00001);
   end

endmodule

bind srt_digit_select srt_digit_select_chk #(.REM_W(REM_W), .REG_OUT(REG_OUT)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .valid_in     (valid_in),
   .rem_msbs     (rem_msbs),
   .valid_out    (valid_out),
   .digit_onehot (digit_onehot),
   .digit_val    (digit_val),
   .cmp_lt       (cmp_lt)
);

// File: tb/srt_digit_select_tb.sv
module srt_digit_select_tb;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 150000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       valid_in = 1'b0;
   logic [7:0] rem_msbs = '0;
   logic [2:0] div_idx = '0;
   logic       valid_out;
   logic [4:0] digit_onehot;
   logic [2:0] digit_val;

   int n_cmp = 0;
   int n_bad = 0;
   int cyc = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   srt_digit_select u_dut (
      .clk(clk), .rst_n(rst_n), .valid_in(valid_in), .rem_msbs(rem_msbs),
      .div_idx(div_idx), .valid_out(valid_out), .digit_onehot(digit_onehot),
      .digit_val(digit_val)
   );

   // reference digit from the threshold rule
   function automatic int ref_digit(input int r, input int idx);
      int d, t2, t1;
      d  = 17 + 2 * idx;
      t2 = (3 * d) / 2;
      t1 = d / 2;
      if (r >= t2)       return 2;
      else if (r >= t1)  return 1;
      else if (r >= -t1) return 0;
      else if (r >= -t2) return -1;
      else               return -2;
   endfunction

   function automatic string region_tag(input int dg);
      case (dg)
         2:       return "R1";
         1:       return "R2";
         0:       return "R3";
         -1:      return "R4";
         default: return "R5";
      endcase
   endfunction

   task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   // behavioural model, one clock of delay
   bit model_valid = 1'b0;
   int model_dig = 0;
   int model_rem = 0;
   int model_idx = 0;
   bit model_loaded = 1'b0;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         model_valid  = 1'b0;
         model_dig    = 0;
         model_loaded = 1'b0;
      end else begin
         model_valid = valid_in;
         if (valid_in) begin
            model_rem    = $signed(rem_msbs);
            model_idx    = div_idx;
            model_dig    = ref_digit(model_rem, model_idx);
            model_loaded = 1'b1;
         end
      end
   end

   // compare every clock, away from the active edge
   bit prev_ok = 1'b0;
   int prev_rem = 0;
   int prev_idx = 0;
   int prev_out = 0;

   always @(negedge clk) begin
      int out_dig;
      int exp_oh;
      string tag;
      out_dig = $signed(digit_val);
      exp_oh  = 1 << (model_dig + 2);
      if (!rst_n) begin
         chk(valid_out == 1'b0, "R10", "valid_out in reset", valid_out, 0);
         chk(digit_onehot == 5'b00100, "R10", "onehot in reset", digit_onehot, 4);
         chk(digit_val == 3'b000, "R10", "digit in reset", out_dig, 0);
         prev_ok = 1'b0;
      end else begin
         chk(valid_out == model_valid, "R8", "valid_out", valid_out, model_valid);
         chk($countones(digit_onehot) == 1, "R6", "onehot population", $countones(digit_onehot), 1);
         tag = model_valid ? region_tag(model_dig) : (model_loaded ? "R9" : "R10");
         chk(digit_onehot == exp_oh[4:0], tag, "onehot", digit_onehot, exp_oh);
         chk(out_dig == model_dig, "R7", "signed digit", out_dig, model_dig);
         if (model_valid) begin
            if (prev_ok && model_idx == prev_idx && model_rem == prev_rem + 1)
               chk(out_dig >= prev_out, "R11", "monotonic digit", out_dig, prev_out);
            prev_ok  = 1'b1;
            prev_rem = model_rem;
            prev_idx = model_idx;
            prev_out = out_dig;
         end else begin
            prev_ok = 1'b0;
         end
      end
   end

   task automatic drive(input bit v, input int r, input int idx);
      @(negedge clk);
      valid_in = v;
      rem_msbs = r[7:0];
      div_idx  = idx[2:0];
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > WATCHDOG) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual %0d expected %0d cycles", cyc, WATCHDOG);
         finish_run();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1..R5 full sweep per index, R11 via ascending order
      for (int i = 0; i < 8; i++)
         for (int r = -128; r < 128; r++) drive(1'b1, r, i);
      // thresholds and their neighbours
      for (int i = 0; i < 8; i++) begin
         int d;
         d = 17 + 2 * i;
         drive(1'b1, (3*d)/2, i);  drive(1'b1, (3*d)/2 - 1, i);
         drive(1'b1, d/2, i);      drive(1'b1, d/2 - 1, i);
         drive(1'b1, -(d/2), i);   drive(1'b1, -(d/2) - 1, i);
         drive(1'b1, -(3*d)/2, i); drive(1'b1, -((3*d)/2) - 1, i);
      end
      // R9: inputs move while valid_in is low
      drive(1'b1, 127, 0);
      for (int k = 0; k < 6; k++) drive(1'b0, -128 + 40 * k, k);
      drive(1'b1, -128, 7);
      for (int k = 0; k < 6; k++) drive(1'b0, 127 - 30 * k, 7 - k);
      // random traffic with gaps
      for (int k = 0; k < 3000; k++)
         drive(($urandom_range(0, 9) < 7), $urandom_range(0, 255) - 128, $urandom_range(0, 7));
      drive(1'b0, 0, 0);
      // R10: reset in mid-stream
      drive(1'b1, 100, 3);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      drive(1'b1, -5, 2);
      drive(1'b0, 0, 0);
      repeat (3) @(negedge clk);
      finish_run();
   end

endmodule